// File: doc/BRIEF.md
# Sleep Entry Delay Sequencer

This block times the two steps a system takes on its way into sleep. Once the suspend-acknowledge input goes low, two independent channels count strobes from a slow timebase. The first channel drives an active-low sleep-clock-enable output. The second drives an active-low bus-output-disable signal. Each channel has its own enable bit and its own programmed delay, held in a 32-bit control register that is written and read over a simple register bus.

Getting out of sleep takes no counting. A wakeup pulse releases the sleep-clock-enable output through logic alone, in the same cycle. Deasserting the suspend input releases the bus-output-disable signal the same way. There is also an ordering rule between the two channels. The bus outputs are never disabled when the sleep-clock channel is enabled and the bus-disable delay is longer than the sleep-clock delay.

The timebase comes in as a one-cycle strobe in the system clock domain. A channel counts from zero on every sleep entry, because its counter clears whenever suspend-acknowledge is high.

Top module: `sleep_seq_top`

## Requirements
- R1: After a synchronous reset, both control registers read 00000000h, and `slpclk_en_n` and `busout_off_n` are both high.
- R2: `reg_addr` 0 selects the sleep-clock register and `reg_addr` 1 selects the bus-disable register. In each register, bit 30 is the channel enable and bits 29:0 are the delay. A read returns exactly the 32 bits last written, bit 31 included, starting the cycle after the write.
- R3: Take the sleep-clock channel with enable 1 and delay D, with `susp_ack_n` held low. `slpclk_en_n` stays high through the first D timebase strobes and goes low right after strobe D+1. For D = 0, that is the first strobe.
- R4: A channel whose enable bit is 0 keeps its output high however many strobes arrive.
- R5: While `wake` is high, `slpclk_en_n` is high in the same cycle, with no clock edge needed. `wake` also clears the sleep-clock channel's count.
- R6: While `susp_ack_n` is high, both counts clear. A new low period therefore counts again from zero.
- R7: Take the bus-disable channel with enable 1 and delay D, with `susp_n` low and no suppression. `busout_off_n` goes low right after strobe D+1.
- R8: When the sleep-clock enable is 1 and the bus-disable delay is greater than the sleep-clock delay, `busout_off_n` stays high. When the sleep-clock enable is 0, the bus-disable delay is not limited.
- R9: While `susp_n` is high, `busout_off_n` is high in the same cycle, with no clock edge needed.
- R10: A delay written while a channel is counting is compared with the count already reached. If the new delay is at or below that count, the output asserts on the next strobe.
- R11: Once asserted, an output stays low through any number of further strobes until its release condition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe of the slow timebase |
| susp_ack_n | input | 1 | Suspend acknowledge, active low; counting runs while low |
| susp_n | input | 1 | Suspend request, active low; high releases the bus outputs |
| wake | input | 1 | Wakeup event, active high |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select (0 sleep-clock, 1 bus-disable) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| slpclk_en_n | output | 1 | Sleep-clock enable, active low |
| busout_off_n | output | 1 | Bus output disable, active low |

## Verification
The assertions assume that `tick_en` is sampled only at clock edges, and that every input holds steady between edges. Only the release paths from `wake` and `susp_n` are combinational. The bench drives every input one time unit after a rising edge and raises `tick_en` for exactly one cycle per strobe, with idle cycles in between. It checks the combinational release by changing `wake` or `susp_n` between edges and sampling the output before the next edge arrives.

// File: rtl/sleep_seq_pkg.sv
// Shared constants and field helpers for the sleep entry sequencer.
// Assumes 32-bit control words: [31] spare, [30] enable, [29:0] delay.
package sleep_seq_pkg;
    localparam int DATA_W     = 32;
    localparam int DLY_W      = 30;
    localparam int EN_BIT     = 30;
    localparam int N_CHAN     = 2;
    localparam int REG_ADDR_W = 1;
    localparam int CH_SCLK    = 0;
    localparam int CH_BUS     = 1;

    // Extract the enable bit of a control word.
    function automatic logic ctl_en(input logic [DATA_W-1:0] w);
        return w[EN_BIT];
    endfunction

    // Extract the delay field of a control word.
    function automatic logic [DLY_W-1:0] ctl_dly(input logic [DATA_W-1:0] w);
        return w[DLY_W-1:0];
    endfunction
endpackage

// File: rtl/sleep_seq_regs.sv
// Control register file: N_REG words, written by strobe, read combinationally.
// Assumes the address is valid whenever the write strobe is high.
module sleep_seq_regs
    import sleep_seq_pkg::*;
#(
    parameter int N_REG = N_CHAN,
    parameter int W     = DATA_W,
    localparam int AW   = (N_REG > 1) ? $clog2(N_REG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  ctl [N_REG]
);
    // Hold each word; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REG; i++) ctl[i] <= '0;
        end else if (wen) begin
            ctl[addr] <= wdata;
        end
    end

    // Return the selected word.
    always_comb rdata = ctl[addr];

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen |=> ctl[$past(addr)] == $past(wdata));
endmodule

// File: rtl/sleep_seq_chan.sv
// One delay channel: counts timebase strobes while running and raises a
// sticky hit once the count has reached the programmed delay.
// Assumes tick is a one-cycle strobe; clr and !run wipe all state.
module sleep_seq_chan #(
    parameter int DLY_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             tick,
    input  logic [DLY_W-1:0] delay,
    output logic             hit
);
    localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

    logic [DLY_W-1:0] cnt;

    // Count strobes up to the delay, then latch the hit until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) begin
            cnt <= '0;
            hit <= 1'b0;
        end else if (tick) begin
            if (cnt >= delay) hit <= 1'b1;
            else              cnt <= cnt + ONE;
        end
    end

    // R3
    hit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(tick));

    // R6
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0 && !hit));

    // R11
    hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && run && !clr) |=> hit);
endmodule

// File: rtl/sleep_seq_top.sv
// Sleep entry delay sequencer top: two control registers, two delay channels,
// active-low outputs with combinational release and the channel ordering rule.
// Assumes tick_en is synchronous to clk; wake and susp_n may change anytime.
module sleep_seq_top
    import sleep_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  susp_ack_n,
    input  logic                  susp_n,
    input  logic                  wake,
    input  logic                  reg_wen,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  slpclk_en_n,
    output logic                  busout_off_n
);
    logic [DATA_W-1:0] ctl [N_CHAN];
    logic [N_CHAN-1:0] hit;
    logic [N_CHAN-1:0] chan_clr;
    logic              suppress;

    sleep_seq_regs #(.N_REG(N_CHAN), .W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (reg_wen),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctl   (ctl)
    );

    // Per-channel clear source: wake for sleep clock, suspend release for bus.
    always_comb begin
        chan_clr         = '0;
        chan_clr[CH_SCLK] = wake;
        chan_clr[CH_BUS]  = susp_n;
    end

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        sleep_seq_chan #(.DLY_W(DLY_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (!susp_ack_n),
            .clr   (chan_clr[g]),
            .tick  (tick_en),
            .delay (ctl_dly(ctl[g])),
            .hit   (hit[g])
        );
    end

    // Ordering rule: bus disable blocked if it would come after the sleep clock.
    always_comb suppress = ctl_en(ctl[CH_SCLK]) &&
                           (ctl_dly(ctl[CH_BUS]) > ctl_dly(ctl[CH_SCLK]));

    // Active-low outputs with combinational release paths.
    always_comb begin
        slpclk_en_n  = !(ctl_en(ctl[CH_SCLK]) && hit[CH_SCLK] && !wake);
        busout_off_n = !(ctl_en(ctl[CH_BUS]) && hit[CH_BUS] && !suppress && !susp_n);
    end

    // R5
    wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> slpclk_en_n);

    // R9
    susp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_n |-> busout_off_n);

    // R8
    order_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[CH_SCLK][EN_BIT] && ctl[CH_BUS][DLY_W-1:0] > ctl[CH_SCLK][DLY_W-1:0])
        |-> busout_off_n);

    // R4
    sclk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[CH_SCLK][EN_BIT] |-> slpclk_en_n);
endmodule

// File: tb/tb_sleep_seq_top.sv
// Directed bench for sleep_seq_top: one task per scenario, each self-checking.
module tb_sleep_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        susp_ack_n = 1'b1;
    logic        susp_n = 1'b1;
    logic        wake = 1'b0;
    logic        reg_wen = 1'b0;
    logic [0:0]  reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        slpclk_en_n;
    logic        busout_off_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sleep_seq_top dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .susp_ack_n(susp_ack_n),
        .susp_n(susp_n), .wake(wake), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slpclk_en_n(slpclk_en_n), .busout_off_n(busout_off_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        step();
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1; step();
            tick_en = 1'b0; step();
        end
    endtask

    task automatic go_idle();
        wake = 1'b0; susp_n = 1'b1; susp_ack_n = 1'b1;
        step(); step();
    endtask

    task automatic enter();
        susp_n = 1'b0; susp_ack_n = 1'b0;
        step();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v); check(v, 32'h0, "R1 reg0");
        rd(1, v); check(v, 32'h0, "R1 reg1");
        check({31'b0, slpclk_en_n}, 32'h1, "R1 slpclk");
        check({31'b0, busout_off_n}, 32'h1, "R1 busout");
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(0, 32'hA5C3_1F07); wr(1, 32'h8000_0001);
        rd(0, v); check(v, 32'hA5C3_1F07, "R2 reg0");
        rd(1, v); check(v, 32'h8000_0001, "R2 reg1 bit31");
        wr(0, 32'h0); wr(1, 32'h0);
    endtask

    task automatic t_sclk_delay(input int d);
        wr(0, 32'h4000_0000 | d);
        enter();
        strobes(d);
        check({31'b0, slpclk_en_n}, 32'h1, "R3 before");
        strobes(1);
        check({31'b0, slpclk_en_n}, 32'h0, "R3 after");
        strobes(5);
        check({31'b0, slpclk_en_n}, 32'h0, "R11 held");
        wake = 1'b1;
        #1 check({31'b0, slpclk_en_n}, 32'h1, "R5 comb release");
        step();
        go_idle();
    endtask

    task automatic t_disabled();
        wr(0, 32'h0000_0002); wr(1, 32'h0000_0001);
        enter();
        strobes(8);
        check({31'b0, slpclk_en_n}, 32'h1, "R4 sclk");
        check({31'b0, busout_off_n}, 32'h1, "R4 bus");
        go_idle();
    endtask

    task automatic t_restart();
        wr(0, 32'h4000_0004);
        enter();
        strobes(3);
        susp_ack_n = 1'b1; step(); step();
        susp_ack_n = 1'b0; step();
        strobes(4);
        check({31'b0, slpclk_en_n}, 32'h1, "R6 restart");
        strobes(1);
        check({31'b0, slpclk_en_n}, 32'h0, "R6 fires");
        go_idle();
    endtask

    task automatic t_bus();
        wr(0, 32'h4000_0005); wr(1, 32'h4000_0003);
        enter();
        strobes(3);
        check({31'b0, busout_off_n}, 32'h1, "R7 before");
        strobes(1);
        check({31'b0, busout_off_n}, 32'h0, "R7 after");
        susp_n = 1'b1;
        #1 check({31'b0, busout_off_n}, 32'h1, "R9 comb release");
        step();
        go_idle();
    endtask

    task automatic t_order();
        wr(0, 32'h4000_0002); wr(1, 32'h4000_0003);
        enter();
        strobes(10);
        check({31'b0, busout_off_n}, 32'h1, "R8 suppressed");
        go_idle();
        wr(0, 32'h0000_0002);
        enter();
        strobes(4);
        check({31'b0, busout_off_n}, 32'h0, "R8 not limited");
        go_idle();
    endtask

    task automatic t_rewrite();
        wr(0, 32'h4000_0014);
        enter();
        strobes(5);
        wr(0, 32'h4000_0003);
        check({31'b0, slpclk_en_n}, 32'h1, "R10 before");
        strobes(1);
        check({31'b0, slpclk_en_n}, 32'h0, "R10 after");
        go_idle();
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regs();
        t_sclk_delay(0);
        t_sclk_delay(6);
        t_disabled();
        t_restart();
        t_bus();
        t_order();
        t_rewrite();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule